// File: doc/BRIEF.md
# Path BIP-8 Error Monitor

This block watches the path-level parity byte of a concatenated payload stream. Each valid byte is folded into an even bit-interleaved parity accumulator. The fold starts on the byte marked as the start of an envelope and runs up to the byte before the next start. The parity of one envelope is compared with the parity byte carried inside the following envelope. A mismatch raises a one-cycle error pulse, sets a sticky interrupt flag and adds to a saturating error counter. The block also produces a remote-error value that a transmitter can insert into each outbound frame.

A single mode input selects the unit of counting. With bit counting, every mismatched parity bit counts, so one envelope can add up to 8. With envelope counting, an envelope with any mismatch counts as one. The remote-error value follows the same mode. Frame alignment, pointer tracking and overhead extraction are done upstream, and they deliver the strobes this block uses.

A three-state controller sequences the monitor. S_WAIT ignores everything until the first envelope start and then moves to S_FIRST (transition "first start"). S_FIRST accumulates the first envelope without checking it and moves to S_CHECK on the next envelope start (transition "reference ready"). S_CHECK compares at every parity-byte strobe and stays there until reset.

Top module: `path_bip_mon`

## Requirements
- R1: After reset, err_cnt, irq_flag, err_pulse and rei_val are all 0.
- R2: Bytes before the first env_start are ignored, and no comparison is made in the first envelope after reset, so its parity byte never causes an error.
- R3: The parity of an envelope is the XOR of every byte with rx_vld=1, starting at the env_start byte and ending at the byte before the next env_start. It is compared with the byte marked by par_pos in the next envelope. On a mismatch, err_pulse is 1 in the cycle after that byte, and otherwise it is 0.
- R4: With env_mode=0, err_cnt increases by the number of differing bits between the computed and the received parity, which ranges from 0 to 8.
- R5: With env_mode=1, err_cnt increases by exactly 1 for an envelope with any mismatch and by 0 for a clean one.
- R6: err_cnt is CNT_W bits wide (32 by default) and holds at all ones instead of wrapping.
- R7: irq_flag is set by any mismatch and stays set until a cycle with irq_rd=1 clears it. A mismatch in the same cycle as irq_rd leaves it set.
- R8: On each frm_sync cycle, rei_val takes the amount from the latest comparison since the previous frm_sync. That amount is the bit count with env_mode=0, or 1/0 with env_mode=1. If no comparison occurred since the previous frm_sync, rei_val becomes 0.
- R9: Bytes with rx_vld=0 do not enter the parity and trigger no comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | W | Payload byte |
| rx_vld | input | 1 | rx_byte carries a payload byte |
| frm_sync | input | 1 | Outbound frame boundary; loads rei_val |
| env_start | input | 1 | First byte of an envelope |
| par_pos | input | 1 | This byte is the received parity byte |
| env_mode | input | 1 | 0 counts errored bits, 1 counts errored envelopes |
| irq_rd | input | 1 | Read strobe that clears irq_flag |
| err_pulse | output | 1 | One-cycle pulse on a parity mismatch |
| err_cnt | output | CNT_W | Saturating error counter |
| irq_flag | output | 1 | Sticky mismatch status |
| rei_val | output | 4 | Remote-error value for the next outbound frame |

## Verification
The monitor is driven with envelopes whose parity byte is built as the previous envelope's true parity XORed with a chosen error mask. Mask 0 separates a correct comparison from any stray error. Single-bit, four-bit and all-ones masks separate a popcount from a flag and show the full 8-per-envelope step. The same masks in envelope mode show the one-per-envelope cap. A first envelope with an arbitrary parity byte, leading bytes before any start, and invalid gap cycles inside an envelope check that the wrong bytes do not leak into the accumulator. A narrow-counter instance and a read strobe placed on the errored byte cover saturation and the set-over-clear priority.

// File: rtl/bip_mon_pkg.sv
package bip_mon_pkg;

    typedef enum logic [1:0] {
        S_WAIT  = 2'd0,
        S_FIRST = 2'd1,
        S_CHECK = 2'd2
    } mon_state_e;

    function automatic logic [3:0] ones8(input logic [7:0] v);
        logic [3:0] n;
        n = '0;
        for (int i = 0; i < 8; i++) begin
            n = n + {3'd0, v[i]};
        end
        return n;
    endfunction

endpackage

// File: rtl/bip8_calc.sv
module bip8_calc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] byte_in,
    input  logic         load,
    input  logic         acc_en,
    input  logic         latch,
    output logic [W-1:0] prev_par
);
    logic [W-1:0] acc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc      <= '0;
            prev_par <= '0;
        end else begin
            if (latch) begin
                prev_par <= acc;
            end
            if (load) begin
                acc <= byte_in;
            end else if (acc_en) begin
                acc <= acc ^ byte_in;
            end
        end
    end

    AST_REF_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !latch |=> $stable(prev_par)) else $error("reference parity moved"); // R3

endmodule

// File: rtl/err_tally.sv
module err_tally #(
    parameter int CNT_W = 32,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_en,
    input  logic [AW-1:0]    amt,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W:0] sum;

    always_comb begin
        sum = {1'b0, cnt} + {{(CNT_W + 1 - AW){1'b0}}, amt};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (inc_en) begin
            cnt <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cnt >= $past(cnt)) else $error("counter wrapped"); // R6
    AST_STEP_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt - $past(cnt)) <= CNT_W'(8)) else $error("step over 8"); // R4

endmodule

// File: rtl/path_bip_mon.sv
module path_bip_mon
    import bip_mon_pkg::*;
#(
    parameter int W     = 8,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     rx_byte,
    input  logic             rx_vld,
    input  logic             frm_sync,
    input  logic             env_start,
    input  logic             par_pos,
    input  logic             env_mode,
    input  logic             irq_rd,
    output logic             err_pulse,
    output logic [CNT_W-1:0] err_cnt,
    output logic             irq_flag,
    output logic [3:0]       rei_val
);
    localparam int AW = 4;

    mon_state_e   state, state_nx;
    logic         take, latch, cmp_en, hit;
    logic [W-1:0] prev_par, diff;
    logic [AW-1:0] nbits, amt, rei_pend;

    always_comb begin
        take   = rx_vld && env_start;
        latch  = take && (state != S_WAIT);
        cmp_en = (state == S_CHECK) && rx_vld && par_pos;
        diff   = rx_byte ^ prev_par;
        nbits  = ones8(diff);
        amt    = env_mode ? {{(AW - 1){1'b0}}, |diff} : nbits;
        hit    = cmp_en && (amt != '0);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_WAIT:  if (take) state_nx = S_FIRST;
            S_FIRST: if (take) state_nx = S_CHECK;
            S_CHECK: state_nx = S_CHECK;
            default: state_nx = S_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_WAIT;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_pulse <= 1'b0;
            irq_flag  <= 1'b0;
            rei_val   <= '0;
            rei_pend  <= '0;
        end else begin
            err_pulse <= hit;
            irq_flag  <= (irq_flag && !irq_rd) || hit;
            if (frm_sync) begin
                rei_val <= rei_pend;
            end
            if (cmp_en) begin
                rei_pend <= amt;
            end else if (frm_sync) begin
                rei_pend <= '0;
            end
        end
    end

    bip8_calc #(.W(W)) u_calc (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_in  (rx_byte),
        .load     (take),
        .acc_en   (rx_vld),
        .latch    (latch),
        .prev_par (prev_par)
    );

    err_tally #(.CNT_W(CNT_W), .AW(AW)) u_tally (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_en (cmp_en),
        .amt    (amt),
        .cnt    (err_cnt)
    );

    AST_NO_EARLY_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        state != S_CHECK |=> !err_pulse) else $error("compare before reference"); // R2
    AST_IRQ_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> irq_flag) else $error("error without status"); // R7
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag && !irq_rd |=> irq_flag) else $error("status dropped"); // R7
    AST_ENV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        env_mode |=> (err_cnt - $past(err_cnt)) <= CNT_W'(1)) else $error("envelope step"); // R5
    AST_REI_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rei_val <= 4'd8) else $error("remote error out of range"); // R8

endmodule

// File: tb/sim_path_bip_mon.sv
module sim_path_bip_mon;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_vld = 1'b0, frm_sync = 1'b0, env_start = 1'b0, par_pos = 1'b0;
    logic        env_mode = 1'b0, irq_rd = 1'b0;
    logic        err_pulse, irq_flag, err_pulse1, irq_flag1;
    logic [31:0] err_cnt;
    logic [3:0]  err_cnt1, rei_val, rei_val1;

    int checks = 0, errors = 0;
    logic [31:0] exp_cnt = 0;
    int   exp_c4 = 0, exp_pend = 0;
    bit   exp_irq = 0, have_prev = 0;
    logic [7:0] prev = 0, seed = 8'h3C;

    always #5 clk = ~clk;

    path_bip_mon u0 (.clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_vld(rx_vld),
        .frm_sync(frm_sync), .env_start(env_start), .par_pos(par_pos), .env_mode(env_mode),
        .irq_rd(irq_rd), .err_pulse(err_pulse), .err_cnt(err_cnt), .irq_flag(irq_flag),
        .rei_val(rei_val));

    path_bip_mon #(.CNT_W(4)) u1 (.clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_vld(rx_vld),
        .frm_sync(frm_sync), .env_start(env_start), .par_pos(par_pos), .env_mode(env_mode),
        .irq_rd(irq_rd), .err_pulse(err_pulse1), .err_cnt(err_cnt1), .irq_flag(irq_flag1),
        .rei_val(rei_val1));

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        rx_vld = 0; env_start = 0; par_pos = 0; irq_rd = 0; frm_sync = 0; rx_byte = 8'hFF;
    endtask

    // one envelope of n bytes; byte 1 holds the parity byte = true parity ^ mask
    task automatic env(input logic [7:0] mask, input int n, input bit gap, input bit rd_par, input string req);
        logic [7:0] acc, b, b3;
        int amt;
        bit errd;
        b3 = have_prev ? (prev ^ mask) : 8'h5A;
        acc = '0;
        errd = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == 2) check(err_pulse == errd, {req, " err_pulse"}, err_pulse, errd);
            if (gap && i == 3) begin
                idle();
                @(negedge clk);
            end
            seed = seed * 8'd13 + 8'd7;
            b = (i == 1) ? b3 : seed;
            rx_byte = b; rx_vld = 1; env_start = (i == 0); par_pos = (i == 1);
            irq_rd = (i == 1) && rd_par; frm_sync = 0;
            acc ^= b;
            if (i == 1) begin
                if (have_prev) begin
                    amt = env_mode ? int'(mask != 0) : $countones(mask);
                    exp_cnt += amt;
                    exp_c4 = (exp_c4 + amt > 15) ? 15 : exp_c4 + amt;
                    exp_pend = amt;
                    errd = (amt != 0);
                end
                exp_irq = (exp_irq && !rd_par) || errd;
            end
        end
        @(negedge clk);
        idle();
        prev = acc;
        have_prev = 1;
        check(err_cnt == exp_cnt, {req, " err_cnt"}, err_cnt, exp_cnt);
        check(irq_flag == exp_irq, "R7 irq_flag", irq_flag, exp_irq);
    endtask

    task automatic frame(input string req);
        @(negedge clk);
        frm_sync = 1;
        @(negedge clk);
        frm_sync = 0;
        check(rei_val == exp_pend[3:0], req, rei_val, exp_pend);
        exp_pend = 0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(err_cnt == 0 && err_pulse == 0, "R1 counter/pulse", err_cnt, 0);
        check(irq_flag == 0 && rei_val == 0, "R1 irq/rei", {irq_flag, rei_val}, 0);
        rst_n = 1;
    endtask

    task automatic t_first();
        // R2: leading valid bytes before any start are ignored
        @(negedge clk);
        rx_vld = 1; rx_byte = 8'hA7;
        @(negedge clk);
        idle();
        env(8'h00, 6, 0, 0, "R2 first envelope");
        check(err_pulse == 0, "R2 no pulse", err_pulse, 0);
    endtask

    task automatic t_clean();
        env(8'h00, 7, 0, 0, "R3 clean parity");
        env(8'h00, 5, 0, 0, "R3 clean parity short");
        frame("R8 no error gives 0");
    endtask

    task automatic t_bitmode();
        env_mode = 0;
        env(8'h01, 6, 0, 0, "R4 one bit");
        frame("R8 rei one bit");
        env(8'hFF, 6, 0, 0, "R4 eight bits");
        frame("R8 rei eight bits");
        env(8'h5A, 6, 0, 0, "R4 four bits");
        frame("R8 rei four bits");
        frame("R8 rei cleared after send");
    endtask

    task automatic t_gap();
        env(8'h00, 8, 1, 0, "R9 invalid gap ignored");
        env(8'h00, 6, 0, 0, "R9 after gap");
    endtask

    task automatic t_envmode();
        env_mode = 1;
        env(8'hFF, 6, 0, 0, "R5 all bits one envelope");
        frame("R8 rei envelope mode");
        env(8'h03, 6, 0, 0, "R5 two bits one envelope");
        env(8'h00, 6, 0, 0, "R5 clean envelope");
        env_mode = 0;
    endtask

    task automatic t_irq();
        @(negedge clk);
        irq_rd = 1;
        @(negedge clk);
        irq_rd = 0;
        exp_irq = 0;
        check(irq_flag == 0, "R7 read clears", irq_flag, 0);
        env(8'h10, 6, 0, 1, "R7 error with read");
        check(irq_flag == 1, "R7 set wins", irq_flag, 1);
        env(8'h00, 6, 0, 0, "R7 held");
        check(irq_flag == 1, "R7 held until read", irq_flag, 1);
    endtask

    task automatic t_sat();
        check(err_cnt1 == 4'(exp_c4), "R6 narrow counter saturates", err_cnt1, exp_c4);
        env(8'hFF, 6, 0, 0, "R6 more errors");
        check(err_cnt1 == 4'd15, "R6 held at all ones", err_cnt1, 15);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_first();
        t_clean();
        t_bitmode();
        t_gap();
        t_envmode();
        t_irq();
        t_sat();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule